// File: doc/BRIEF.md
# Descriptor-Chained Memory-to-Stream Walker

This block moves packets from memory onto an outgoing word stream. It follows a chain of descriptors, each holding a pointer to the next descriptor, a buffer address, a control word and a status word. A packet may be split across several descriptors. Start and end flags in each control word mark where a packet begins and ends. The walker sends each buffer out one 32-bit word per beat. Alongside the data it presents six sideband words taken from the descriptor that opened the packet. After each descriptor it writes a completion status back to memory and reports the new current pointer.

A register block around the walker owns the current and tail pointers and the run and idle flags. A kick pulse asks the walker to start. The walker runs only when the channel is running and not idle. It stops when it has finished the tail descriptor, when it fetches a descriptor already marked complete, or when a packet grows past the size limit. Each stop is reported with an idle-set pulse, so that the register block can update its idle flag.

Top module: `sg_mm2s_walker`

## Requirements
- R1: After reset the walker issues no memory access, holds the stream invalid and drives every pulse output low.
- R2: A kick is ignored unless `run_i` is 1 and `idle_i` is 0. An ignored kick causes no memory access and no pulse.
- R3: The walker reads a descriptor at the current pointer as 32-bit words. It reads the next pointer at byte 0x00, the buffer address at 0x08, the control word at 0x18, the status word at 0x1C and the six sideband words at 0x20 through 0x34. Control bits 22:0 hold the byte length, bit 26 marks the end of a packet and bit 27 marks its start.
- R4: The buffer of a descriptor leaves as ceil(length/4) beats. The beats are read from ascending word addresses starting at the buffer address. A beat is held unchanged while `st_ready_i` is low. A descriptor of zero length sends no beat.
- R5: `st_last_o` is high only on the final beat of a descriptor that has the end-of-packet flag set.
- R6: `st_app_o` shows the six sideband words of the most recent start-of-packet descriptor, with word 0 in bits 31:0. It does not change on descriptors without the start flag.
- R7: After the beats of a descriptor, the walker writes the length with bit 31 set to the status word at current+0x1C. In the following cycle `cur_upd_o` pulses and `cur_ptr_o` carries that descriptor's next pointer.
- R8: `done_o` pulses once for each end-of-packet descriptor, in the same cycle as its `cur_upd_o`.
- R9: When the descriptor just written back sits at the tail pointer, `idle_set_o` pulses together with `cur_upd_o` and the walk stops. Descriptors past the tail are left untouched.
- R10: A fetched descriptor whose status bit 31 is already set stops the walk with an `idle_set_o` pulse. It produces no beat, no memory write and no pointer update.
- R11: The packet byte count restarts at each start-of-packet descriptor and adds each descriptor's length. If adding a length would exceed `MAX_PKT_BYTES` (16384 by default), `pkt_err_o` and `idle_set_o` pulse and the walk stops. That descriptor sends no beat and is not written back. A packet of exactly the limit is accepted.
- R12: The memory port never reads and writes in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| kick_i | input | 1 | Start request pulse |
| run_i | input | 1 | Channel running flag |
| idle_i | input | 1 | Channel idle flag |
| cur_ptr_i | input | AW | Current descriptor address loaded on a kick |
| tail_ptr_i | input | AW | Address of the last descriptor to process |
| mem_rd_o | output | 1 | Memory read strobe; data returns one cycle later |
| mem_wr_o | output | 1 | Memory write strobe |
| mem_addr_o | output | AW | Byte address of the memory access |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Memory read data, one cycle after the strobe |
| st_data_o | output | 32 | Stream data word |
| st_valid_o | output | 1 | Stream beat valid |
| st_ready_i | input | 1 | Stream sink ready |
| st_last_o | output | 1 | Final beat of a packet |
| st_app_o | output | 192 | Six sideband words of the current packet |
| cur_ptr_o | output | AW | Updated current descriptor address |
| cur_upd_o | output | 1 | Pulse: cur_ptr_o holds a new value |
| idle_set_o | output | 1 | Pulse: the walk has stopped |
| done_o | output | 1 | Pulse: a packet has completed |
| pkt_err_o | output | 1 | Pulse: packet size limit exceeded |

## Verification
A wrong fetch index or a wrongly captured descriptor field shows up within one descriptor. It appears as a beat read from the wrong buffer word, a wrong beat count, a misplaced last flag, or a status write to the wrong address. A stale packet byte count or a stale sideband latch stays hidden until the next descriptor that continues a packet or opens a new one. At that point it shows as a false or missing `pkt_err_o` pulse, or as sideband words carried over from the wrong packet. A bad stop decision shows after the tail writeback: the walker either keeps fetching past the tail or stops early without the expected `done_o` pulse.

// File: rtl/sgd_pkg.sv
// Shared constants, the walker state type and the descriptor word map.
// Assumes 32-bit descriptor words and byte addressing.
package sgd_pkg;
    localparam int WORD_W     = 32;
    localparam int NAPP       = 6;
    localparam int DESC_WORDS = 4 + NAPP;
    localparam int IDX_NEXT   = 0;
    localparam int IDX_BUF    = 1;
    localparam int IDX_CTRL   = 2;
    localparam int IDX_STAT   = 3;
    localparam int IDX_APP0   = 4;
    localparam int EOF_BIT    = 26;
    localparam int SOF_BIT    = 27;
    localparam int CMPL_BIT   = 31;
    localparam logic [7:0] STAT_OFS = 8'h1C;

    typedef enum logic [2:0] {
        ST_IDLE, ST_FETCH, ST_CHECK, ST_STREAM, ST_WRBACK
    } walk_state_e;

    // Byte offset of fetch slot idx inside a descriptor.
    function automatic logic [7:0] desc_word_offset(input logic [3:0] idx);
        case (idx)
            4'd0:    desc_word_offset = 8'h00;
            4'd1:    desc_word_offset = 8'h08;
            4'd2:    desc_word_offset = 8'h18;
            4'd3:    desc_word_offset = STAT_OFS;
            default: desc_word_offset = 8'h20 + {2'b00, idx - 4'd4, 2'b00};
        endcase
    endfunction
endpackage

// File: rtl/sgd_desc_capture.sv
// Captures fetched descriptor words into fields and holds the packet sideband.
// Assumes one captured word per cycle, indexed by its fetch slot.
module sgd_desc_capture
    import sgd_pkg::*;
#(
    parameter int AW   = 32,
    parameter int LENW = 23
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cap_en,
    input  logic [3:0]             cap_idx,
    input  logic [WORD_W-1:0]      cap_data,
    input  logic                   latch_app,
    output logic [AW-1:0]          next_ptr,
    output logic [AW-1:0]          buf_ptr,
    output logic [LENW-1:0]        len,
    output logic                   eof,
    output logic                   sof,
    output logic                   cmpl,
    output logic [NAPP*WORD_W-1:0] pkt_app
);
    logic [NAPP*WORD_W-1:0] app_live;

    // Store the pointer, control and status words of the fetched descriptor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_ptr <= '0;
            buf_ptr  <= '0;
            len      <= '0;
            eof      <= 1'b0;
            sof      <= 1'b0;
            cmpl     <= 1'b0;
        end else if (cap_en) begin
            case (cap_idx)
                4'(IDX_NEXT): next_ptr <= AW'(cap_data);
                4'(IDX_BUF):  buf_ptr  <= AW'(cap_data);
                4'(IDX_CTRL): begin
                    len <= cap_data[LENW-1:0];
                    eof <= cap_data[EOF_BIT];
                    sof <= cap_data[SOF_BIT];
                end
                4'(IDX_STAT): cmpl <= cap_data[CMPL_BIT];
                default: ;
            endcase
        end
    end

    for (genvar g = 0; g < NAPP; g++) begin : g_app
        // Fetched sideband word g; copied into the packet latch on a start flag.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                app_live[g*WORD_W +: WORD_W] <= '0;
                pkt_app[g*WORD_W +: WORD_W]  <= '0;
            end else begin
                if (cap_en && cap_idx == 4'(IDX_APP0 + g))
                    app_live[g*WORD_W +: WORD_W] <= cap_data;
                if (latch_app)
                    pkt_app[g*WORD_W +: WORD_W] <= app_live[g*WORD_W +: WORD_W];
            end
        end
    end
endmodule

// File: rtl/sgd_pkt_len.sv
// Tracks the running byte count of the open packet and flags when the limit is exceeded.
// Assumes commit is raised only for a descriptor that was not flagged.
module sgd_pkt_len #(
    parameter int LENW          = 23,
    parameter int MAX_PKT_BYTES = 16384
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            commit,
    input  logic            sof,
    input  logic [LENW-1:0] len,
    output logic            over
);
    localparam int POSW = LENW + 2;

    logic [POSW-1:0] pos;
    logic [POSW-1:0] sum;

    // Sum of the base and the new length, compared with the limit.
    always_comb begin
        sum  = (sof ? '0 : pos) + POSW'(len);
        over = sum > POSW'(MAX_PKT_BYTES);
    end

    // Keep the accepted byte count.
    always_ff @(posedge clk) begin
        if (!rst_n)      pos <= '0;
        else if (commit) pos <= sum;
    end
endmodule

// File: rtl/sgd_beat_reg.sv
// Single output register for stream beats with valid/ready handshake.
// Assumes load arrives only when the slot is empty or emptying this cycle.
module sgd_beat_reg #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] load_data,
    input  logic          load_last,
    input  logic          ready,
    output logic          valid,
    output logic [DW-1:0] data,
    output logic          last
);
    // Hold a beat until the sink accepts it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            data  <= '0;
            last  <= 1'b0;
        end else if (load) begin
            valid <= 1'b1;
            data  <= load_data;
            last  <= load_last;
        end else if (valid && ready) begin
            valid <= 1'b0;
        end
    end
endmodule

// File: rtl/sg_mm2s_walker.sv
// Walks a descriptor chain and sends each buffer out as stream beats. Writes
// status back and reports pointer updates and stops. Assumes memory read
// data arrives exactly one cycle after mem_rd_o and that buffers are word aligned.
module sg_mm2s_walker
    import sgd_pkg::*;
#(
    parameter int AW            = 32,
    parameter int LENW          = 23,
    parameter int MAX_PKT_BYTES = 16384
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   kick_i,
    input  logic                   run_i,
    input  logic                   idle_i,
    input  logic [AW-1:0]          cur_ptr_i,
    input  logic [AW-1:0]          tail_ptr_i,
    output logic                   mem_rd_o,
    output logic                   mem_wr_o,
    output logic [AW-1:0]          mem_addr_o,
    output logic [WORD_W-1:0]      mem_wdata_o,
    input  logic [WORD_W-1:0]      mem_rdata_i,
    output logic [WORD_W-1:0]      st_data_o,
    output logic                   st_valid_o,
    input  logic                   st_ready_i,
    output logic                   st_last_o,
    output logic [NAPP*WORD_W-1:0] st_app_o,
    output logic [AW-1:0]          cur_ptr_o,
    output logic                   cur_upd_o,
    output logic                   idle_set_o,
    output logic                   done_o,
    output logic                   pkt_err_o
);
    localparam int BW = LENW - 1;

    walk_state_e      state;
    logic [AW-1:0]    cur;
    logic [3:0]       fidx, pidx;
    logic             f_pend, s_pend, s_last_pend;
    logic [BW-1:0]    bidx, beats, beats_calc;
    logic [LENW:0]    len_rnd;
    logic             f_issue, s_issue, stream_done, commit, pkt_over;
    logic [AW-1:0]    d_next, d_buf;
    logic [LENW-1:0]  d_len;
    logic             d_eof, d_sof, d_cmpl;

    sgd_desc_capture #(.AW(AW), .LENW(LENW)) cap_i (
        .clk(clk), .rst_n(rst_n), .cap_en(f_pend), .cap_idx(pidx),
        .cap_data(mem_rdata_i), .latch_app(commit && d_sof),
        .next_ptr(d_next), .buf_ptr(d_buf), .len(d_len), .eof(d_eof),
        .sof(d_sof), .cmpl(d_cmpl), .pkt_app(st_app_o)
    );

    sgd_pkt_len #(.LENW(LENW), .MAX_PKT_BYTES(MAX_PKT_BYTES)) plen_i (
        .clk(clk), .rst_n(rst_n), .commit(commit), .sof(d_sof),
        .len(d_len), .over(pkt_over)
    );

    sgd_beat_reg #(.DW(WORD_W)) beat_i (
        .clk(clk), .rst_n(rst_n), .load(s_pend), .load_data(mem_rdata_i),
        .load_last(s_last_pend), .ready(st_ready_i), .valid(st_valid_o),
        .data(st_data_o), .last(st_last_o)
    );

    // Issue conditions for descriptor and buffer reads, and the beat count.
    always_comb begin
        f_issue     = (state == ST_FETCH) && (fidx < 4'(DESC_WORDS));
        s_issue     = (state == ST_STREAM) && !s_pend && (bidx != beats) &&
                      (!st_valid_o || st_ready_i);
        stream_done = (state == ST_STREAM) && !s_pend && (bidx == beats) &&
                      (!st_valid_o || st_ready_i);
        commit      = (state == ST_CHECK) && !d_cmpl && !pkt_over;
        len_rnd     = {1'b0, d_len} + (LENW+1)'(3);
        beats_calc  = len_rnd[LENW:2];
    end

    // Memory port address, strobes and writeback word.
    always_comb begin
        mem_rd_o    = f_issue || s_issue;
        mem_wr_o    = (state == ST_WRBACK);
        mem_wdata_o = {1'b1, {(WORD_W-1-LENW){1'b0}}, d_len};
        if (f_issue)
            mem_addr_o = cur + {{(AW-8){1'b0}}, desc_word_offset(fidx)};
        else if (s_issue)
            mem_addr_o = d_buf + {{(AW-BW-2){1'b0}}, bidx, 2'b00};
        else if (state == ST_WRBACK)
            mem_addr_o = cur + {{(AW-8){1'b0}}, STAT_OFS};
        else
            mem_addr_o = '0;
    end

    // Walk sequencing, read tracking and registered event pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            cur         <= '0;
            fidx        <= '0;
            pidx        <= '0;
            f_pend      <= 1'b0;
            s_pend      <= 1'b0;
            s_last_pend <= 1'b0;
            bidx        <= '0;
            beats       <= '0;
            cur_ptr_o   <= '0;
            cur_upd_o   <= 1'b0;
            idle_set_o  <= 1'b0;
            done_o      <= 1'b0;
            pkt_err_o   <= 1'b0;
        end else begin
            cur_upd_o  <= 1'b0;
            idle_set_o <= 1'b0;
            done_o     <= 1'b0;
            pkt_err_o  <= 1'b0;
            f_pend     <= f_issue;
            pidx       <= fidx;
            s_pend     <= s_issue;
            if (f_issue) fidx <= fidx + 4'd1;
            if (s_issue) begin
                bidx        <= bidx + 1'b1;
                s_last_pend <= d_eof && (bidx == beats - 1'b1);
            end
            case (state)
                ST_IDLE: begin
                    if (kick_i && run_i && !idle_i) begin
                        cur   <= cur_ptr_i;
                        fidx  <= '0;
                        state <= ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    if (f_pend && pidx == 4'(DESC_WORDS-1)) state <= ST_CHECK;
                end
                ST_CHECK: begin
                    if (d_cmpl) begin
                        idle_set_o <= 1'b1;
                        state      <= ST_IDLE;
                    end else if (pkt_over) begin
                        pkt_err_o  <= 1'b1;
                        idle_set_o <= 1'b1;
                        state      <= ST_IDLE;
                    end else begin
                        beats <= beats_calc;
                        bidx  <= '0;
                        state <= (beats_calc == '0) ? ST_WRBACK : ST_STREAM;
                    end
                end
                ST_STREAM: begin
                    if (stream_done) state <= ST_WRBACK;
                end
                ST_WRBACK: begin
                    cur_upd_o <= 1'b1;
                    cur_ptr_o <= d_next;
                    done_o    <= d_eof;
                    if (cur == tail_ptr_i) begin
                        idle_set_o <= 1'b1;
                        state      <= ST_IDLE;
                    end else begin
                        cur   <= d_next;
                        fidx  <= '0;
                        state <= ST_FETCH;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sgd_mm2s_checker.sv
// Port-level properties of the walker, attached by bind.
// Assumes synchronous active-low reset.
module sgd_mm2s_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        mem_rd,
    input logic        mem_wr,
    input logic [31:0] mem_wdata,
    input logic        st_valid,
    input logic        st_ready,
    input logic [31:0] st_data,
    input logic        st_last,
    input logic        idle_set,
    input logic        done,
    input logic        cur_upd,
    input logic        pkt_err
);
    assert_one_mem_op_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    assert_beat_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && !st_ready) |=> (st_valid && $stable(st_data) && $stable(st_last)));

    assert_status_cmpl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> mem_wdata[31]);

    assert_done_with_upd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> cur_upd);

    assert_stop_drained_R9: assert property (@(posedge clk) disable iff (!rst_n)
        idle_set |-> !st_valid);

    assert_err_stops_R11: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_err |-> (idle_set && !cur_upd));
endmodule

bind sg_mm2s_walker sgd_mm2s_checker chk_i (
    .clk(clk), .rst_n(rst_n), .mem_rd(mem_rd_o), .mem_wr(mem_wr_o),
    .mem_wdata(mem_wdata_o), .st_valid(st_valid_o), .st_ready(st_ready_i),
    .st_data(st_data_o), .st_last(st_last_o), .idle_set(idle_set_o),
    .done(done_o), .cur_upd(cur_upd_o), .pkt_err(pkt_err_o)
);

// File: tb/sg_mm2s_walker_tb_top.sv
`timescale 1ns/1ps
module sg_mm2s_walker_tb_top;
    localparam int NVEC = 4;
    // {stall[28], len2[27:20], len1[19:12], len0[11:4], ndesc[3:0]}
    localparam logic [31:0] VEC [NVEC] = '{
        32'h0000_0101, 32'h1000_A082, 32'h1070_0043, 32'h0012_0FF3
    };
    localparam logic [31:0] SOF = 32'h0800_0000;
    localparam logic [31:0] EOF = 32'h0400_0000;
    localparam logic [31:0] CMP = 32'h8000_0000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic kick = 1'b0, run_i = 1'b1, idle_in = 1'b0;
    logic [31:0] cur_i = '0, tail_i = '0;
    logic mem_rd, mem_wr;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [31:0] st_data;
    logic st_valid, st_last, st_ready;
    logic [191:0] st_app;
    logic [31:0] cur_o;
    logic cur_upd, idle_set, done, pkt_err;
    logic stall_mode = 1'b0;
    int cyc = 0;

    logic [31:0] mem [1024];
    logic        tb_we = 1'b0;
    logic [31:0] tb_addr = '0, tb_data = '0;
    int rd_tot = 0, wr_tot = 0;

    int rx_total = 0, done_tot = 0, idle_tot = 0, upd_tot = 0, err_tot = 0;
    int mon_base = 0;
    logic [31:0]  last_cur = '0;
    logic [31:0]  rx_data [256];
    logic         rx_last [256];
    logic [191:0] rx_app  [256];

    int checks = 0, errors = 0;
    logic [31:0]  exp_data [256];
    logic [191:0] exp_app  [256];
    int rx0, done0, idle0, upd0, err0, rd0, wr0, n, total, blen, nb, bad_d, bad_l, bad_a;
    logic [31:0] vec, ctrl;

    always #10 clk = ~clk;

    sg_mm2s_walker dut_i (
        .clk(clk), .rst_n(rst_n), .kick_i(kick), .run_i(run_i), .idle_i(idle_in),
        .cur_ptr_i(cur_i), .tail_ptr_i(tail_i), .mem_rd_o(mem_rd), .mem_wr_o(mem_wr),
        .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
        .st_data_o(st_data), .st_valid_o(st_valid), .st_ready_i(st_ready),
        .st_last_o(st_last), .st_app_o(st_app), .cur_ptr_o(cur_o), .cur_upd_o(cur_upd),
        .idle_set_o(idle_set), .done_o(done), .pkt_err_o(pkt_err)
    );

    assign st_ready = !stall_mode || (cyc % 3 != 0);

    always @(posedge clk) cyc <= cyc + 1;

    // Memory model: one-cycle read latency; the bench preloads through tb_we.
    always @(posedge clk) begin
        if (mem_rd) begin
            mem_rdata <= mem[mem_addr[11:2]];
            rd_tot <= rd_tot + 1;
        end
        if (tb_we) mem[tb_addr[11:2]] <= tb_data;
        else if (mem_wr) begin
            mem[mem_addr[11:2]] <= mem_wdata;
            wr_tot <= wr_tot + 1;
        end
    end

    // Output monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (st_valid && st_ready) begin
            if (rx_total - mon_base < 256) begin
                rx_data[rx_total - mon_base] = st_data;
                rx_last[rx_total - mon_base] = st_last;
                rx_app[rx_total - mon_base]  = st_app;
            end
            rx_total = rx_total + 1;
        end
        if (done) done_tot = done_tot + 1;
        if (idle_set) idle_tot = idle_tot + 1;
        if (pkt_err) err_tot = err_tot + 1;
        if (cur_upd) begin
            upd_tot = upd_tot + 1;
            last_cur = cur_o;
        end
    end

    function automatic logic [31:0] dptr(input int i);
        return 32'h100 + 32'(i) * 32'h40;
    endfunction
    function automatic logic [31:0] bptr(input int i);
        return 32'h800 + 32'(i) * 32'h100;
    endfunction
    function automatic logic [31:0] expw(input int v, input int i, input int k);
        return 32'hB000_0000 | (32'(v) << 16) | (32'(i) << 8) | 32'(k);
    endfunction
    function automatic logic [191:0] appv(input int v, input int i);
        logic [191:0] r;
        for (int j = 0; j < 6; j++)
            r[j*32 +: 32] = 32'hA000_0000 | (32'(v) << 12) | (32'(i) << 4) | 32'(j);
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic poke(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        tb_we = 1'b1; tb_addr = a; tb_data = d;
    endtask
    task automatic poke_end();
        @(negedge clk);
        tb_we = 1'b0;
    endtask

    task automatic build_desc(input int i, input logic [31:0] c, input logic [31:0] st,
                              input int v);
        logic [191:0] a;
        a = appv(v, i);
        poke(dptr(i) + 32'h00, dptr(i + 1));
        poke(dptr(i) + 32'h04, 32'h0);
        poke(dptr(i) + 32'h08, bptr(i));
        poke(dptr(i) + 32'h0C, 32'h0);
        poke(dptr(i) + 32'h18, c);
        poke(dptr(i) + 32'h1C, st);
        for (int j = 0; j < 6; j++) poke(dptr(i) + 32'h20 + 32'(4 * j), a[j*32 +: 32]);
    endtask

    task automatic snap();
        rx0 = rx_total; done0 = done_tot; idle0 = idle_tot; upd0 = upd_tot;
        err0 = err_tot; rd0 = rd_tot; wr0 = wr_tot; mon_base = rx_total;
    endtask

    task automatic run_walk(input logic [31:0] cp, input logic [31:0] tp,
                            input logic rn, input logic idl, input int maxc);
        snap();
        @(negedge clk);
        cur_i = cp; tail_i = tp; run_i = rn; idle_in = idl; kick = 1'b1;
        @(negedge clk);
        kick = 1'b0;
        for (int c = 0; c < maxc; c++) begin
            @(negedge clk);
            if (idle_tot != idle0) break;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic cmp_beats(input int cnt, input string tag);
        bad_d = 0; bad_l = 0; bad_a = 0;
        for (int k = 0; k < cnt && k < 256; k++) begin
            if (rx_data[k] !== exp_data[k]) bad_d++;
            if (rx_last[k] !== (k == cnt - 1)) bad_l++;
            if (rx_app[k] !== exp_app[k]) bad_a++;
        end
        chk(bad_d == 0, {"R3 R4 beat data ", tag}, 64'(bad_d), 0);
        chk(bad_l == 0, {"R5 last placement ", tag}, 64'(bad_l), 0);
        chk(bad_a == 0, {"R6 sideband words ", tag}, 64'(bad_a), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL R9 watchdog actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: quiet outputs after reset
        chk({st_valid, mem_rd, mem_wr, idle_set, cur_upd, done, pkt_err} == 7'b0,
            "R1 reset state", 64'({st_valid, mem_rd, mem_wr, idle_set, cur_upd, done, pkt_err}), 0);

        // Vector table: one packet spread over 1..3 descriptors.
        for (int v = 0; v < NVEC; v++) begin
            vec = VEC[v];
            n = int'(vec[3:0]);
            stall_mode = vec[28];
            total = 0;
            for (int i = 0; i < n; i++) begin
                blen = int'(vec[4 + 8*i +: 8]);
                ctrl = 32'(blen) | ((i == 0) ? SOF : 32'h0) | ((i == n - 1) ? EOF : 32'h0);
                build_desc(i, ctrl, 32'h0, v);
                nb = (blen + 3) / 4;
                for (int k = 0; k < nb; k++) begin
                    poke(bptr(i) + 32'(4 * k), expw(v, i, k));
                    exp_data[total] = expw(v, i, k);
                    exp_app[total] = appv(v, 0);
                    total++;
                end
            end
            poke_end();
            run_walk(dptr(0), dptr(n - 1), 1'b1, 1'b0, 20000);
            chk(rx_total - rx0 == total, "R4 beat count", 64'(rx_total - rx0), 64'(total));
            cmp_beats(total, "table");
            for (int i = 0; i < n; i++) begin
                blen = int'(vec[4 + 8*i +: 8]);
                chk(mem[dptr(i) >> 2 | 32'h7] == (CMP | 32'(blen)), "R7 status writeback",
                    64'(mem[(dptr(i) >> 2) | 32'h7]), 64'(CMP | 32'(blen)));
            end
            chk(last_cur == dptr(n) && upd_tot - upd0 == n, "R7 pointer update",
                64'(last_cur), 64'(dptr(n)));
            chk(done_tot - done0 == 1, "R8 completion pulse", 64'(done_tot - done0), 1);
            chk(idle_tot - idle0 == 1, "R9 stop at tail", 64'(idle_tot - idle0), 1);
        end
        stall_mode = 1'b0;

        // R2: kick ignored when not running, and when idle.
        build_desc(0, SOF | EOF | 32'd4, 32'h0, 9);
        poke_end();
        run_walk(dptr(0), dptr(0), 1'b0, 1'b0, 30);
        chk(rd_tot == rd0 && idle_tot == idle0, "R2 kick while stopped", 64'(rd_tot - rd0), 0);
        run_walk(dptr(0), dptr(0), 1'b1, 1'b1, 30);
        chk(rd_tot == rd0 && idle_tot == idle0, "R2 kick while idle", 64'(rd_tot - rd0), 0);

        // R10: descriptor already complete.
        build_desc(0, SOF | EOF | 32'd4, CMP | 32'd4, 9);
        poke_end();
        run_walk(dptr(0), dptr(0), 1'b1, 1'b0, 2000);
        chk(idle_tot - idle0 == 1, "R10 stop on complete", 64'(idle_tot - idle0), 1);
        chk(rx_total == rx0 && wr_tot == wr0 && upd_tot == upd0, "R10 no side effects",
            64'(rx_total - rx0 + wr_tot - wr0 + upd_tot - upd0), 0);

        // R9 / R6: tail in the middle of a chain of single-descriptor packets.
        build_desc(0, SOF | EOF | 32'd4, 32'h0, 8);
        build_desc(1, SOF | EOF | 32'd8, 32'h0, 8);
        build_desc(2, SOF | EOF | 32'd4, 32'h0, 8);
        poke(bptr(0), expw(8, 0, 0));
        poke(bptr(1), expw(8, 1, 0));
        poke(bptr(1) + 32'h4, expw(8, 1, 1));
        poke_end();
        exp_data[0] = expw(8, 0, 0); exp_app[0] = appv(8, 0);
        exp_data[1] = expw(8, 1, 0); exp_app[1] = appv(8, 1);
        exp_data[2] = expw(8, 1, 1); exp_app[2] = appv(8, 1);
        run_walk(dptr(0), dptr(1), 1'b1, 1'b0, 2000);
        chk(rx_total - rx0 == 3, "R4 beats before tail", 64'(rx_total - rx0), 3);
        chk(rx_data[0] == exp_data[0] && rx_data[2] == exp_data[2], "R4 data two packets",
            64'(rx_data[2]), 64'(exp_data[2]));
        chk(rx_app[0] == exp_app[0] && rx_app[1] == exp_app[1] && rx_app[2] == exp_app[2],
            "R6 sideband per packet", 64'(rx_app[1][31:0]), 64'(exp_app[1][31:0]));
        chk(rx_last[0] && !rx_last[1] && rx_last[2], "R5 last per packet",
            64'({rx_last[0], rx_last[1], rx_last[2]}), 3'b101);
        chk(done_tot - done0 == 2, "R8 two completions", 64'(done_tot - done0), 2);
        chk(mem[(dptr(2) >> 2) | 32'h7] == 32'h0 && last_cur == dptr(2),
            "R9 past tail untouched", 64'(mem[(dptr(2) >> 2) | 32'h7]), 0);

        // R11: packet running over the limit on its second descriptor.
        build_desc(0, SOF | 32'h2000, 32'h0, 7);
        build_desc(1, EOF | 32'h2001, 32'h0, 7);
        poke_end();
        run_walk(dptr(0), dptr(1), 1'b1, 1'b0, 20000);
        chk(err_tot - err0 == 1 && idle_tot - idle0 == 1, "R11 overflow flagged",
            64'(err_tot - err0), 1);
        chk(rx_total - rx0 == 2048 && upd_tot - upd0 == 1 && done_tot == done0,
            "R11 only first descriptor sent", 64'(rx_total - rx0), 2048);
        chk(mem[(dptr(0) >> 2) | 32'h7] == (CMP | 32'h2000) && mem[(dptr(1) >> 2) | 32'h7] == 32'h0,
            "R11 writeback stops", 64'(mem[(dptr(1) >> 2) | 32'h7]), 0);

        // R11: packet of exactly the limit is accepted.
        build_desc(0, SOF | EOF | 32'h4000, 32'h0, 6);
        poke_end();
        run_walk(dptr(0), dptr(0), 1'b1, 1'b0, 20000);
        chk(err_tot == err0 && rx_total - rx0 == 4096 && done_tot - done0 == 1,
            "R11 limit accepted", 64'(rx_total - rx0), 4096);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule